// File: doc/BRIEF.md
# Token Scheduling Controller

This block orders the pairing search of an array of syndrome cells, laid out as ROWS rows by COLS columns, in which every cell keeps a short history of parity results. It hands a single token to one cell at a time. Each cell that holds the token acts as the sink for one search, and the cells themselves carry out that search. Visits are organised in nested passes. The outer pass raises a hop limit from 1 up to HOP_MAX. The inner pass moves a base history slot from 0 up to DEPTH-1. Every base slot gets one full sweep over the array.

Each row has its own small master. The master reports whether any history bit in its row is set, and the controller moves straight past rows that report nothing. A cell can only receive the token when the number of history entries held exceeds the base slot by more than the threshold THV. After a grant, the controller waits for the cell's finish signal, or for a timeout of the hop limit plus MARGIN cycles, whichever comes first. At the end of each sweep it broadcasts a clear of the cells' token-seen flags. If the oldest entry is 0 in every cell and at least one entry is held, it also broadcasts a pop and restarts the whole search. Each new measurement round is passed on to the cells as a push, in the same cycle it arrives.

Top module: `token_sched_ctrl`

## Requirements
- R1: While `rst` is high, `tok_o` and `pop_o` stay 0, `restart_o` is 1, `base_o` is 0 and `hop_o` is 1.
- R2: `push_o` is high in exactly the cycles in which `meas_i` is high. A push that arrives during a sweep changes neither the order nor the timing of the grants.
- R3: The entry count starts at 0 after reset. It rises by one per push and saturates at DEPTH. It falls by one per pop, and a push and a pop in the same cycle cancel. A grant at base b happens only when count > b + THV.
- R4: Rows are visited in increasing order and cells in increasing column order. A row receives a grant only if at least one of its history bits is set. `cell_hist_i` bit `(r*COLS+c)*DEPTH+k` is history entry k of cell (r,c), with k = 0 the oldest. During a grant, `cur_row_o` equals `tok_row_o`.
- R5: Each sweep starts with a one-cycle `restart_o`, which carries that sweep's `base_o` and `hop_o`. Bases run from 0 to DEPTH-1 for each hop limit. The hop limit runs from 1 to HOP_MAX and then wraps back to 1.
- R6: If `finish_i` stays low, the wait after a grant lasts hop+MARGIN cycles. The next grant in the same row therefore comes hop+MARGIN+1 cycles after the previous one.
- R7: A `finish_i` seen in the first cycle after a grant ends the wait. The next grant in the same row then follows 2 cycles after the previous one.
- R8: At the end of a sweep, `pop_o` pulses for one cycle when entry 0 of every cell is 0 and the count is non-zero. It is followed by `restart_o` with base 0 and hop 1. Each pop removes one entry.
- R9: `flag_clr_o` pulses for one cycle at the end of every sweep, and the cycle right after it is always a `restart_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_i | input | 1 | New measurement round |
| finish_i | input | 1 | The cell holding the token has finished |
| cell_hist_i | input | ROWS*COLS*DEPTH | History bits of all cells |
| tok_o | output | 1 | Token grant pulse |
| tok_row_o | output | RW | Row of the granted cell |
| tok_col_o | output | CW | Column of the granted cell |
| restart_o | output | 1 | Start of a sweep |
| cur_row_o | output | RW | Row currently being walked |
| base_o | output | BW | Base history slot of the current sweep |
| hop_o | output | HW | Hop limit of the current sweep |
| push_o | output | 1 | Push broadcast to all cells |
| pop_o | output | 1 | Pop broadcast to all cells |
| flag_clr_o | output | 1 | Clear of the cells' token-seen flags |

## Verification
In the cycle where `restart_o` shows base 0 and hop 1, the first grant is due three cycles later: one cycle on the idle row, one on the busy row, and then the cell itself. Later grants in a row follow 2 cycles (finish) or hop+5 cycles (timeout) after the one before. Crossing into another busy row adds one cycle. The scoreboard holds the expected row, column, base, hop and spacing of each grant. It measures spacing on a cycle counter, sampled at the falling edge. A pop must be followed in the very next cycle by a restart at base 0 and hop 1, and a restart that comes after a sweep must have the flag clear in the cycle just before it. Below-threshold and saturation behaviour show up as grants that are missing or extra against the queue.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [2:0] {
        ST_RESTART,
        ST_ROW,
        ST_CELL,
        ST_WAIT,
        ST_END
    } tsc_state_e;

    typedef struct packed {
        logic restart;
        logic grant;
        logic clr;
        logic pop;
    } tsc_evt_t;

    // last timer value of a wait window for a given hop limit
    function automatic int wait_last(input int hop, input int margin);
        return hop + margin - 1;
    endfunction

endpackage

// File: rtl/tsc_row_master.sv
module tsc_row_master #(
    parameter int COLS  = 4,
    parameter int DEPTH = 7
) (
    input  logic [COLS*DEPTH-1:0] row_hist_i,
    output logic                  busy_o,
    output logic                  oldest_clr_o
);
    assign busy_o = |row_hist_i;

    always_comb begin
        oldest_clr_o = 1'b1;
        for (int c = 0; c < COLS; c++) begin
            if (row_hist_i[c*DEPTH]) oldest_clr_o = 1'b0;
        end
    end
endmodule

// File: rtl/tsc_depth_cnt.sv
module tsc_depth_cnt #(
    parameter int DEPTH = 7,
    localparam int NW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [NW-1:0] cnt_o
);
    logic [NW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (push_i && !pop_i) begin
            if (cnt_q != NW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
        end else if (pop_i && !push_i) begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= NW'(DEPTH)); // R3
    AST_CNT_INC: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && cnt_q < NW'(DEPTH)) |=> cnt_q == $past(cnt_q) + 1'b1); // R3
    AST_CNT_PAIR: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/tsc_hop_timer.sv
module tsc_hop_timer #(
    parameter int HOP_MAX = 8,
    parameter int MARGIN  = 4,
    localparam int HW = $clog2(HOP_MAX + 1),
    localparam int TW = $clog2(HOP_MAX + MARGIN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          run_i,
    input  logic [HW-1:0] hop_i,
    output logic          expired_o
);
    logic [TW-1:0] tmr_q;
    logic [TW-1:0] lim;

    assign lim = TW'(tsc_pkg::wait_last(int'(hop_i), MARGIN));

    always_ff @(posedge clk) begin
        if (rst || clear_i) tmr_q <= '0;
        else if (run_i)     tmr_q <= tmr_q + 1'b1;
    end

    assign expired_o = run_i && (tmr_q == lim);

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_i |-> tmr_q <= lim); // R6
endmodule

// File: rtl/token_sched_ctrl.sv
module token_sched_ctrl
    import tsc_pkg::*;
#(
    parameter int ROWS    = 5,
    parameter int COLS    = 4,
    parameter int DEPTH   = 7,
    parameter int THV     = 3,
    parameter int HOP_MAX = 8,
    parameter int MARGIN  = 4,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int BW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int HW = $clog2(HOP_MAX + 1),
    localparam int NW = $clog2(DEPTH + 1),
    localparam int HB = ROWS * COLS * DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          meas_i,
    input  logic          finish_i,
    input  logic [HB-1:0] cell_hist_i,
    output logic          tok_o,
    output logic [RW-1:0] tok_row_o,
    output logic [CW-1:0] tok_col_o,
    output logic          restart_o,
    output logic [RW-1:0] cur_row_o,
    output logic [BW-1:0] base_o,
    output logic [HW-1:0] hop_o,
    output logic          push_o,
    output logic          pop_o,
    output logic          flag_clr_o
);
    tsc_state_e    st_q, st_d;
    logic [RW-1:0] row_q, row_d;
    logic [CW-1:0] col_q, col_d;
    logic [BW-1:0] base_q, base_d;
    logic [HW-1:0] hop_q, hop_d;
    tsc_evt_t      evt;
    logic          step;
    logic          gate;
    logic          expired;
    logic [NW-1:0] cnt;
    logic [ROWS-1:0] row_busy;
    logic [ROWS-1:0] row_old_clr;
    logic          all_old_clr;

    // per-row masters
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        tsc_row_master #(.COLS(COLS), .DEPTH(DEPTH)) u_rm (
            .row_hist_i  (cell_hist_i[r*COLS*DEPTH +: COLS*DEPTH]),
            .busy_o      (row_busy[r]),
            .oldest_clr_o(row_old_clr[r])
        );
    end

    assign all_old_clr = &row_old_clr;

    tsc_depth_cnt #(.DEPTH(DEPTH)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .push_i(meas_i),
        .pop_i (evt.pop),
        .cnt_o (cnt)
    );

    tsc_hop_timer #(.HOP_MAX(HOP_MAX), .MARGIN(MARGIN)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (evt.grant),
        .run_i    (st_q == ST_WAIT),
        .hop_i    (hop_q),
        .expired_o(expired)
    );

    assign gate = int'(cnt) > int'(base_q) + THV;

    always_comb begin
        st_d   = st_q;
        row_d  = row_q;
        col_d  = col_q;
        base_d = base_q;
        hop_d  = hop_q;
        evt    = '0;
        step   = 1'b0;
        unique case (st_q)
            ST_RESTART: begin
                evt.restart = 1'b1;
                row_d = '0;
                col_d = '0;
                st_d  = ST_ROW;
            end
            ST_ROW: begin
                if (row_busy[row_q]) begin
                    col_d = '0;
                    st_d  = ST_CELL;
                end else if (row_q == RW'(ROWS - 1)) begin
                    st_d = ST_END;
                end else begin
                    row_d = row_q + 1'b1;
                end
            end
            ST_CELL: begin
                if (gate) begin
                    evt.grant = 1'b1;
                    st_d = ST_WAIT;
                end else begin
                    step = 1'b1;
                end
            end
            ST_WAIT: begin
                if (finish_i || expired) step = 1'b1;
            end
            ST_END: begin
                evt.clr = 1'b1;
                evt.pop = all_old_clr && (cnt != '0);
                st_d = ST_RESTART;
                if (evt.pop) begin
                    base_d = '0;
                    hop_d  = HW'(1);
                end else if (base_q == BW'(DEPTH - 1)) begin
                    base_d = '0;
                    hop_d  = (hop_q == HW'(HOP_MAX)) ? HW'(1) : hop_q + 1'b1;
                end else begin
                    base_d = base_q + 1'b1;
                end
            end
            default: st_d = ST_RESTART;
        endcase
        if (step) begin
            if (col_q != CW'(COLS - 1)) begin
                col_d = col_q + 1'b1;
                st_d  = ST_CELL;
            end else if (row_q != RW'(ROWS - 1)) begin
                row_d = row_q + 1'b1;
                st_d  = ST_ROW;
            end else begin
                st_d = ST_END;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_RESTART;
            row_q  <= '0;
            col_q  <= '0;
            base_q <= '0;
            hop_q  <= HW'(1);
        end else begin
            st_q   <= st_d;
            row_q  <= row_d;
            col_q  <= col_d;
            base_q <= base_d;
            hop_q  <= hop_d;
        end
    end

    assign tok_o      = evt.grant;
    assign tok_row_o  = row_q;
    assign tok_col_o  = col_q;
    assign cur_row_o  = row_q;
    assign restart_o  = evt.restart;
    assign base_o     = base_q;
    assign hop_o      = hop_q;
    assign push_o     = meas_i;
    assign pop_o      = evt.pop;
    assign flag_clr_o = evt.clr;

    AST_GRANT_ROW_BUSY: assert property (@(posedge clk) disable iff (rst)
        tok_o |-> row_busy[tok_row_o]); // R4
    AST_GRANT_DEPTH: assert property (@(posedge clk) disable iff (rst)
        tok_o |-> int'(cnt) > THV); // R3
    AST_HOP_RANGE: assert property (@(posedge clk) disable iff (rst)
        (hop_o >= HW'(1)) && (hop_o <= HW'(HOP_MAX))); // R5
    AST_BASE_MOVES_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(base_o) |-> $past(flag_clr_o)); // R5
    AST_POP_RESTART: assert property (@(posedge clk) disable iff (rst)
        pop_o |=> (restart_o && base_o == '0 && hop_o == HW'(1))); // R8
    AST_CLR_RESTART: assert property (@(posedge clk) disable iff (rst)
        flag_clr_o |=> restart_o); // R9
endmodule

// File: tb/token_sched_ctrl_test.sv
module token_sched_ctrl_test;
    localparam int ROWS_T = 3;
    localparam int COLS_T = 2;
    localparam int DEP_T  = 6;
    localparam int THV_T  = 3;
    localparam int HOPS_T = 2;
    localparam int MARG_T = 4;
    localparam int HB_T   = ROWS_T * COLS_T * DEP_T;

    typedef struct {
        int row;
        int col;
        int base;
        int hop;
        int gap;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic meas_i = 1'b0;
    logic finish_i = 1'b0;
    logic [HB_T-1:0] hist = '0;
    logic tok_o, restart_o, push_o, pop_o, flag_clr_o;
    logic [1:0] tok_row_o, cur_row_o;
    logic [0:0] tok_col_o;
    logic [2:0] base_o;
    logic [1:0] hop_o;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_tok = 0;
    int pop_cnt = 0;
    int tok_cnt = 0;
    bit sb_on = 1'b0;
    bit prev_pop = 1'b0;
    bit prev_clr = 1'b0;
    bit seen_clr = 1'b0;
    bit done = 1'b0;

    token_sched_ctrl #(
        .ROWS(ROWS_T), .COLS(COLS_T), .DEPTH(DEP_T), .THV(THV_T),
        .HOP_MAX(HOPS_T), .MARGIN(MARG_T)
    ) uut (
        .clk(clk), .rst(rst), .meas_i(meas_i), .finish_i(finish_i),
        .cell_hist_i(hist), .tok_o(tok_o), .tok_row_o(tok_row_o),
        .tok_col_o(tok_col_o), .restart_o(restart_o), .cur_row_o(cur_row_o),
        .base_o(base_o), .hop_o(hop_o), .push_o(push_o), .pop_o(pop_o),
        .flag_clr_o(flag_clr_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // driver side of the scoreboard: expected grants of one full hop loop
    task automatic enq(input int m, input bit fin, input bit [2:0] rows);
        for (int h = 1; h <= HOPS_T; h++)
            for (int b = 0; b < DEP_T; b++)
                if (m > b + THV_T)
                    for (int r = 0; r < ROWS_T; r++)
                        if (rows[r])
                            for (int c = 0; c < COLS_T; c++) begin
                                exp_t e;
                                e.row = r; e.col = c; e.base = b; e.hop = h;
                                e.gap = (c == 0) ? 0 : (fin ? 2 : h + MARG_T + 1);
                                q.push_back(e);
                            end
    endtask

    task automatic pulse_push();
        @(negedge clk); #1 meas_i = 1'b1;
        @(negedge clk); #1 meas_i = 1'b0;
    endtask

    task automatic wait_loop_start();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(restart_o && base_o == 0 && hop_o == 1) && n < 2000);
        if (n >= 2000) check(1'b0, "R5 loop start not seen", n, 0);
    endtask

    task automatic wait_drain();
        int n = 0;
        while (q.size() != 0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(q.size() == 0, "R4 expected grants missing", q.size(), 0);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (meas_i) check(push_o == 1'b1, "R2 push_o with meas_i", push_o, 1);
            if (tok_o) begin
                tok_cnt++;
                check(cur_row_o == tok_row_o, "R4 cur_row during grant", cur_row_o, tok_row_o);
                if (sb_on) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R3 unexpected grant row", tok_row_o, -1);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(tok_row_o == e.row, "R4 grant row", tok_row_o, e.row);
                        check(tok_col_o == e.col, "R4 grant col", tok_col_o, e.col);
                        check(base_o == e.base, "R5 grant base", base_o, e.base);
                        check(hop_o == e.hop, "R5 grant hop", hop_o, e.hop);
                        if (e.gap > 0) begin
                            if (e.gap == 2)
                                check(cyc - last_tok == e.gap, "R7 finish spacing", cyc - last_tok, e.gap);
                            else
                                check(cyc - last_tok == e.gap, "R6 timeout spacing", cyc - last_tok, e.gap);
                        end
                    end
                end
                last_tok = cyc;
            end
            if (prev_pop)
                check(restart_o && base_o == 0 && hop_o == 1, "R8 restart after pop",
                      {restart_o, base_o, hop_o}, {1'b1, 3'd0, 2'd1});
            if (restart_o && seen_clr)
                check(prev_clr, "R9 clear before restart", prev_clr, 1);
            if (pop_o) pop_cnt++;
            if (flag_clr_o) seen_clr = 1'b1;
            prev_pop = pop_o;
            prev_clr = flag_clr_o;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog R5 act=%0d exp=<20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int p0;
        // R1 reset state
        repeat (2) @(negedge clk);
        check(tok_o == 0, "R1 tok_o in reset", tok_o, 0);
        check(pop_o == 0, "R1 pop_o in reset", pop_o, 0);
        check(restart_o == 1, "R1 restart_o in reset", restart_o, 1);
        check(base_o == 0, "R1 base_o in reset", base_o, 0);
        check(hop_o == 1, "R1 hop_o in reset", hop_o, 1);
        #1 rst = 1'b0;

        // empty array: no grants, no pops
        sb_on = 1'b1;
        repeat (60) @(negedge clk);
        check(tok_cnt == 0, "R4 grants on empty rows", tok_cnt, 0);
        check(pop_cnt == 0, "R8 pop with zero count", pop_cnt, 0);

        // row 1 busy, count 3: below threshold
        #1 hist[(1*COLS_T + 1)*DEP_T] = 1'b1;
        repeat (3) pulse_push();
        repeat (100) @(negedge clk);
        check(tok_cnt == 0, "R3 grant below threshold", tok_cnt, 0);
        check(pop_cnt == 0, "R8 pop with oldest set", pop_cnt, 0);

        // fourth push at loop start: base 0 only, timeout spacing
        wait_loop_start();
        #1 meas_i = 1'b1;
        enq(4, 1'b0, 3'b010);
        @(negedge clk); #1 meas_i = 1'b0;
        wait_drain();
        #1 hist = '0;
        p0 = pop_cnt;
        repeat (150) @(negedge clk);
        check(pop_cnt - p0 == 4, "R8 pops drain count", pop_cnt - p0, 4);
        check(q.size() == 0, "R4 no grants after clear", q.size(), 0);

        // saturation, finish, two busy rows, push mid-sweep
        sb_on = 1'b0;
        #1 begin
            finish_i = 1'b1;
            hist[(1*COLS_T + 0)*DEP_T] = 1'b1;
            hist[(2*COLS_T + 1)*DEP_T + 3] = 1'b1;
        end
        repeat (8) pulse_push();
        wait_loop_start();
        #1 begin
            sb_on = 1'b1;
            enq(6, 1'b1, 3'b110);
        end
        repeat (6) @(negedge clk);
        pulse_push();
        wait_drain();
        #1 begin
            hist = '0;
            finish_i = 1'b0;
        end
        p0 = pop_cnt;
        repeat (150) @(negedge clk);
        check(pop_cnt - p0 == 6, "R3 saturated count popped", pop_cnt - p0, 6);
        check(q.size() == 0, "R2 queue empty at end", q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule